// File: doc/BRIEF.md
# Serial Port with Transmit Holding Register

This block is a memory-mapped asynchronous serial port. Software reaches it through a simple register port that holds two registers. One is a character register: a write queues a byte for transmission, and a read returns the last received byte. The other is a status register.

The transmit side has a shift register and a one-entry holding register in front of it. Software can therefore queue a second character while the first is still on the line. The two characters leave back to back, with no idle gap between frames. The receive side keeps one byte, a data-ready flag and an overrun flag.

A single-cycle interrupt pulse is raised when each transmitted character completes and when each received character lands. Every frame has one start bit, eight data bits sent least significant bit first, and one stop bit. Each bit lasts `CLKS_PER_BIT` clock cycles.

The register port has no back-pressure. Every selected cycle is one complete access: a write takes effect at that clock edge, and read data is valid in the same cycle. A write only carries a character, so the write-data port is one character wide, while read data is word-wide. The serial pins have no handshake of their own. The interrupt is a plain pulse.

Top module: `serial_port_hs`

## Requirements
- R1: After reset the status register reads 0x06: bit 1 (shift empty) and bit 2 (holding empty) are set, while bit 0 (data ready) and bit 4 (overrun) are clear. The tx line is high and the interrupt is low.
- R2: A write to the character register (offset 0x70) while shift-empty is set loads the shifter and clears shift-empty. The tx line then sends a low start bit, the 8 data bits LSB first and a high stop bit, each held for CLKS_PER_BIT cycles.
- R3: A character write while shift-empty is clear goes to the holding register and clears holding-empty. Two writes in a row therefore read back status 0x00, and both frames follow each other on the line with no idle time between them.
- R4: When a frame ends and the holding register is empty, shift-empty is set again and the line idles high. If a character is held, it moves into the shifter, holding-empty is set and the next frame starts at once.
- R5: The interrupt is high for one cycle at the end of every transmitted frame.
- R6: A received frame sets data-ready, makes the byte readable at offset 0x70, and pulses the interrupt for one cycle.
- R7: Reading the character register clears data-ready.
- R8: A frame that arrives while data-ready is still set sets overrun (bit 4), and the new byte replaces the old one.
- R9: Any write to the status register (offset 0x74) clears overrun, shift-empty and holding-empty, and leaves data-ready unchanged.
- R10: A low pulse on rx that is no longer low at the middle of the start bit is discarded: data-ready stays clear and no interrupt is raised.
- R11: Reads at any address other than 0x70 and 0x74 return zero. Writes to such addresses change neither the status nor the tx line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | CHAR_W | Write data (character) |
| bus_rdata_o | output | DATA_W | Read data, valid in the access cycle |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that the register port carries at most one access per cycle. They also assume that rx idles high and that frames arrive at exactly CLKS_PER_BIT cycles per bit. With those inputs, the receive and transmit events and the flag updates line up cycle for cycle.

The stimulus keeps within these assumptions in three ways:
- It drives each access for a single cycle, away from the clock edge.
- It sends receive frames bit-exact at the configured rate.
- It issues status writes only when no frame is completing.

Reset is reapplied between scenarios. A status write clears the transmit flags, so a fresh reset returns the port to a known state.

// File: rtl/serial_port_hs_pkg.sv
package serial_port_hs_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  localparam int ST_READY_BIT = 0;
  localparam int ST_SHEMPTY_BIT = 1;
  localparam int ST_HOLDEMPTY_BIT = 2;
  localparam int ST_OVERRUN_BIT = 4;
endpackage

// File: rtl/serial_port_hs_tx.sv
module serial_port_hs_tx #(
  parameter int CLKS_PER_BIT = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CHAR_W-1:0] wr_char_i,
  input  logic              clr_flags_i,
  output logic              tx_o,
  output logic              sh_empty_o,
  output logic              hold_empty_o,
  output logic              done_o
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int FRAME_W = CHAR_W + 2;
  localparam int BW = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(CLKS_PER_BIT - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  logic [FRAME_W-1:0] frame_q;
  logic [CHAR_W-1:0]  hold_q;
  logic [CW-1:0]      tick_q;
  logic [BW-1:0]      bit_q;
  logic               busy_q;
  logic               sh_empty_q;
  logic               hold_empty_q;

  assign done_o = busy_q && (bit_q == LAST_BIT) && (tick_q == LAST_TICK);
  assign tx_o = busy_q ? frame_q[0] : 1'b1;
  assign sh_empty_o = sh_empty_q;
  assign hold_empty_o = hold_empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      hold_q <= '0;
      tick_q <= '0;
      bit_q <= '0;
      busy_q <= 1'b0;
      sh_empty_q <= 1'b1;
      hold_empty_q <= 1'b1;
    end else begin
      if (busy_q) begin
        if (tick_q == LAST_TICK) begin
          tick_q <= '0;
          frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
          bit_q <= bit_q + 1'b1;
        end else begin
          tick_q <= tick_q + 1'b1;
        end
      end
      if (done_o) begin
        busy_q <= 1'b0;
        if (!hold_empty_q) begin
          frame_q <= {1'b1, hold_q, 1'b0};
          busy_q <= 1'b1;
          bit_q <= '0;
          tick_q <= '0;
          if (wr_i) hold_q <= wr_char_i;
          else hold_empty_q <= 1'b1;
        end else if (wr_i) begin
          frame_q <= {1'b1, wr_char_i, 1'b0};
          busy_q <= 1'b1;
          bit_q <= '0;
          tick_q <= '0;
        end else begin
          sh_empty_q <= 1'b1;
        end
      end else if (wr_i) begin
        if (sh_empty_q) begin
          frame_q <= {1'b1, wr_char_i, 1'b0};
          busy_q <= 1'b1;
          bit_q <= '0;
          tick_q <= '0;
          sh_empty_q <= 1'b0;
        end else begin
          hold_q <= wr_char_i;
          hold_empty_q <= 1'b0;
        end
      end
      if (clr_flags_i) begin
        sh_empty_q <= 1'b0;
        hold_empty_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_port_hs_rx.sv
module serial_port_hs_rx
  import serial_port_hs_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  output logic              got_o,
  output logic [CHAR_W-1:0] char_o
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int IW = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
  localparam logic [CW-1:0] LAST_TICK = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_TICK = CW'((CLKS_PER_BIT / 2) - 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(CHAR_W - 1);

  logic [1:0]        sync_q;
  logic              line;
  rx_state_t         state_q;
  logic [CW-1:0]     tick_q;
  logic [IW-1:0]     idx_q;
  logic [CHAR_W-1:0] shift_q;
  logic              got_q;

  assign line = sync_q[1];
  assign got_o = got_q;
  assign char_o = shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      state_q <= RX_IDLE;
      tick_q <= '0;
      idx_q <= '0;
      shift_q <= '0;
      got_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      got_q <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          tick_q <= '0;
          if (!line) state_q <= RX_START;
        end
        RX_START: begin
          if (tick_q == HALF_TICK) begin
            tick_q <= '0;
            idx_q <= '0;
            state_q <= line ? RX_IDLE : RX_DATA;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (tick_q == LAST_TICK) begin
            tick_q <= '0;
            shift_q <= {line, shift_q[CHAR_W-1:1]};
            if (idx_q == LAST_IDX) state_q <= RX_STOP;
            else idx_q <= idx_q + 1'b1;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        default: begin
          if (tick_q == LAST_TICK) begin
            tick_q <= '0;
            got_q <= 1'b1;
            state_q <= RX_IDLE;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/serial_port_hs.sv
module serial_port_hs
  import serial_port_hs_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int CHAR_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CHAR_OFS = 'h70,
  parameter int STAT_OFS = 'h74
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CHAR_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] CHAR_A = ADDR_W'(CHAR_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  logic              char_hit, stat_hit;
  logic              tx_wr, stat_wr, data_rd;
  logic              sre, hre, tx_done;
  logic              rx_got;
  logic [CHAR_W-1:0] rx_char;
  logic [CHAR_W-1:0] rx_q;
  logic              dr_q, ovr_q, irq_q;
  logic [DATA_W-1:0] status;

  assign char_hit = (bus_addr_i == CHAR_A);
  assign stat_hit = (bus_addr_i == STAT_A);
  assign tx_wr   = bus_sel_i && bus_we_i && char_hit;
  assign stat_wr = bus_sel_i && bus_we_i && stat_hit;
  assign data_rd = bus_sel_i && !bus_we_i && char_hit;

  serial_port_hs_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .CHAR_W(CHAR_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .wr_i(tx_wr), .wr_char_i(bus_wdata_i),
    .clr_flags_i(stat_wr), .tx_o(tx_o), .sh_empty_o(sre),
    .hold_empty_o(hre), .done_o(tx_done)
  );

  serial_port_hs_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .CHAR_W(CHAR_W)) rx_ui (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .got_o(rx_got), .char_o(rx_char)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q <= 1'b0;
      ovr_q <= 1'b0;
      rx_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= tx_done || rx_got;
      if (stat_wr) ovr_q <= 1'b0;
      if (rx_got) begin
        if (dr_q) ovr_q <= 1'b1;
        dr_q <= 1'b1;
        rx_q <= rx_char;
      end else if (data_rd) begin
        dr_q <= 1'b0;
      end
    end
  end

  always_comb begin
    status = '0;
    status[ST_READY_BIT] = dr_q;
    status[ST_SHEMPTY_BIT] = sre;
    status[ST_HOLDEMPTY_BIT] = hre;
    status[ST_OVERRUN_BIT] = ovr_q;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      if (char_hit) bus_rdata_o = DATA_W'(rx_q);
      else if (stat_hit) bus_rdata_o = status;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/serial_port_hs_chk.sv
module serial_port_hs_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_line,
  input logic irq,
  input logic sre,
  input logic hre,
  input logic dr,
  input logic ovr,
  input logic tx_done,
  input logic rx_got,
  input logic tx_wr,
  input logic stat_wr,
  input logic data_rd
);
  // R4
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sre |-> tx_line);
  // R3
  held_means_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hre |-> !sre);
  // R2
  load_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && sre) |=> !sre);
  // R5
  tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> irq);
  // R6
  rx_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_got |=> (dr && irq));
  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_got && dr) |=> ovr);
  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rx_got) |=> !dr);
  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !rx_got) |=> (!ovr && !sre && !hre));
  // R9
  stat_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !rx_got) |=> (dr == $past(dr)));
endmodule

bind serial_port_hs serial_port_hs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_line(tx_o), .irq(irq_o), .sre(sre),
  .hre(hre), .dr(dr_q), .ovr(ovr_q), .tx_done(tx_done), .rx_got(rx_got),
  .tx_wr(tx_wr), .stat_wr(stat_wr), .data_rd(data_rd)
);

// File: tb/serial_port_hs_tb_top.sv
module serial_port_hs_tb_top;
  localparam int CPB = 16;
  localparam logic [7:0] A_CHAR = 8'h70;
  localparam logic [7:0] A_STAT = 8'h74;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  logic we = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [31:0] rdata;
  logic rx = 1'b1;
  logic tx;
  logic irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  serial_port_hs #(.CLKS_PER_BIT(CPB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rx_i(rx), .tx_o(tx), .irq_o(irq)
  );

  always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sel = 1'b0; rx = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] b);
    logic [9:0] f;
    f = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rx = f[i];
      repeat (CPB) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    bus_read(A_STAT, d);
    check("R1 status", d, 32'h6);
    check("R1 tx idle", {31'b0, tx}, 32'h1);
    check("R1 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_frames(input logic [7:0] c0, input logic [7:0] c1, input bit two);
    logic [19:0] got;
    logic [19:0] exp;
    int base;
    int n;
    do_reset();
    base = irq_cnt;
    n = two ? 20 : 10;
    bus_write(A_CHAR, c0);
    if (two) bus_write(A_CHAR, c1);
    repeat (two ? CPB/2 - 1 : CPB/2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got[i] = tx;
      if (i != n - 1) repeat (CPB) @(negedge clk);
    end
    exp = {1'b1, c1, 1'b0, 1'b1, c0, 1'b0};
    if (two) check("R3 back-to-back frames", 32'(got), 32'(exp));
    else check("R2 frame bits", 32'(got[9:0]), 32'(exp[9:0]));
    repeat (CPB + 2) @(negedge clk);
    check("R5 irq per frame", irq_cnt - base, two ? 2 : 1);
    check("R4 line idle after", {31'b0, tx}, 32'h1);
  endtask

  task automatic t_hold_status();
    logic [31:0] d;
    int base;
    do_reset();
    base = irq_cnt;
    bus_write(A_CHAR, 8'h5A);
    bus_read(A_STAT, d);
    check("R2 shift-empty cleared", d, 32'h4);
    bus_write(A_CHAR, 8'hC3);
    bus_read(A_STAT, d);
    check("R3 holding used", d, 32'h0);
    repeat (CPB * 10) @(negedge clk);
    bus_read(A_STAT, d);
    check("R4 hand-off sets hold-empty", d, 32'h4);
    repeat (CPB * 11) @(negedge clk);
    bus_read(A_STAT, d);
    check("R4 shift-empty after last", d, 32'h6);
    check("R5 irq count", irq_cnt - base, 2);
  endtask

  task automatic t_receive();
    logic [31:0] d;
    int base;
    do_reset();
    base = irq_cnt;
    send_frame(8'h3C);
    check("R6 irq on receive", irq_cnt - base, 1);
    bus_read(A_STAT, d);
    check("R6 data-ready", d, 32'h7);
    bus_read(A_CHAR, d);
    check("R6 byte", d, 32'h3C);
    bus_read(A_STAT, d);
    check("R7 read clears ready", d, 32'h6);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    do_reset();
    send_frame(8'h11);
    send_frame(8'hA2);
    bus_read(A_STAT, d);
    check("R8 overrun", d, 32'h17);
    bus_write(A_STAT, 8'h00);
    bus_read(A_STAT, d);
    check("R9 status write keeps ready only", d, 32'h1);
    bus_read(A_CHAR, d);
    check("R8 newest byte", d, 32'hA2);
    bus_read(A_STAT, d);
    check("R7 ready cleared", d, 32'h0);
  endtask

  task automatic t_glitch();
    logic [31:0] d;
    int base;
    do_reset();
    base = irq_cnt;
    rx = 1'b0;
    repeat (CPB/4) @(negedge clk);
    rx = 1'b1;
    repeat (CPB * 12) @(negedge clk);
    bus_read(A_STAT, d);
    check("R10 glitch ignored", d, 32'h6);
    check("R10 no irq", irq_cnt - base, 0);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    int lows;
    do_reset();
    bus_read(8'h00, d);
    check("R11 unmapped read", d, 32'h0);
    bus_read(8'h78, d);
    check("R11 unmapped read 0x78", d, 32'h0);
    bus_write(8'h78, 8'h55);
    lows = 0;
    for (int i = 0; i < 3 * CPB; i++) begin
      @(negedge clk);
      if (!tx) lows++;
    end
    check("R11 no transmit", lows, 0);
    bus_read(A_STAT, d);
    check("R11 status untouched", d, 32'h6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_frames(8'hA5, 8'h00, 1'b0);
    t_frames(8'h0F, 8'hB1, 1'b1);
    t_hold_status();
    t_receive();
    t_overrun();
    t_glitch();
    t_decode();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule